// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block is the digital counter path that sits around a frequency-multiplying phase-locked loop. It has three counters. A reference pre-divider turns the input reference clock into the comparison clock for the phase detector. A feedback divider divides the oscillator clock before that clock goes back to the detector. An output scaler divides the oscillator clock by a power of two to form the delivered clock. The resulting output frequency is Fref·(M+8) / ((P+2)·2^S). The detector, charge pump, filter and oscillator are analog and are not part of this block. In simulation the oscillator is an ordinary clock.

The three codes come from one of two places. They can be driven directly on input pins, or they can come from a 16-bit configuration word that is loaded through a single-cycle parallel write port. An input selects the source. Any code outside the legal window is clamped to the nearest legal value, and an illegal code raises a sticky error flag. New codes take effect only when a counter reaches the end of its count, so no divided clock ever produces a short pulse. A power-down input holds every counter at its start and forces every divided output low.

Top module: `pllDivChain`

## Requirements
- R1: `refDivOut` has a period of P+2 cycles of `refClk`, where P is the 6-bit reference code.
- R2: `fbDivOut` has a period of M+8 cycles of `vcoClk`, where M is the 8-bit feedback code.
- R3: `clkOut` is `vcoClk` divided by 2^S for a 2-bit code S of 1 to 3. When S=0, `clkOut` follows `vcoClk` itself: high just after a rising edge and low just after a falling edge.
- R4: For a ratio N, each divided output is high for ceil(N/2) input cycles and low for floor(N/2) input cycles.
- R5: With `useReg`=1 the codes come from the configuration word, laid out as M in bits 15:8, P in bits 7:2 and S in bits 1:0. That word is loaded from `wrData` on a `refClk` edge while `wrEn`=1. With `useReg`=0 the codes come from `pinP`, `pinM` and `pinS`.
- R6: Out-of-range codes are clamped. P=0 acts as 1 and P=63 acts as 62. M=0 acts as 1 and M>248 acts as 248.
- R7: `codeErr` is 0 after reset. It becomes 1 one `refClk` cycle after the selected P or M code is illegal. It then stays 1 until `rstN` is asserted, even after legal codes return.
- R8: While `powerDown`=1 every output is low. After `powerDown` falls, `refDivOut` and `fbDivOut` each rise on the first edge of their own clock.
- R9: A code change made in the middle of a period does not affect that period. The new ratio starts at the next terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; also clocks the configuration word and the error flag |
| vcoClk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerDown | input | 1 | Holds all counters and forces all outputs low |
| useReg | input | 1 | 1 selects the configuration word, 0 selects the pins |
| wrEn | input | 1 | Write strobe for the configuration word |
| wrData | input | 16 | Configuration word data {M, P, S} |
| pinM | input | 8 | Feedback code from pins |
| pinP | input | 6 | Reference code from pins |
| pinS | input | 2 | Output scaler code from pins |
| refDivOut | output | 1 | Divided reference clock |
| fbDivOut | output | 1 | Divided feedback clock |
| clkOut | output | 1 | Scaled output clock |
| codeErr | output | 1 | Sticky illegal-code flag |

## Verification
The hardest case to reach from the ports is a code change that lands partway through a long period. It is the only way to show that the old ratio completes before the new one is loaded. The bench sets the longest legal reference ratio and waits for a rising edge of `refDivOut`. It then immediately switches to the shortest ratio and measures the high and low runs of the current period and of the next one. The rest of the stimulus sweeps every legal reference code, a spread of feedback codes that includes both ends of the range, every scaler code and each clamp case. Every measured run is compared against ceil(N/2) and floor(N/2), computed in the bench.

// File: rtl/pllDivPkg.sv
package pllDivPkg;
  localparam int PCODE_W = 6;
  localparam int MCODE_W = 8;
  localparam int SCODE_W = 2;
  localparam int CFG_W   = MCODE_W + PCODE_W + SCODE_W;
  localparam int PRE_RW  = PCODE_W + 1;
  localparam int FB_RW   = MCODE_W + 1;
  localparam int POST_RW = $clog2((1 << ((1 << SCODE_W) - 1)) + 1);

  typedef struct packed {
    logic               hold;
    logic [PRE_RW-1:0]  preRatio;
    logic [FB_RW-1:0]   fbRatio;
    logic [POST_RW-1:0] postRatio;
  } dpCtrl_t;
endpackage

// File: rtl/divCounter.sv
module divCounter #(
  parameter int W = 8,
  parameter bit UNITY_PASS = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hold,
  input  logic [W-1:0] ratioIn,
  output logic         divOut
);
  logic [W-1:0] cnt, curRatio, nextCnt, nextRatio;
  logic [W:0]   halfHigh;
  logic         atTerm, divQ;

  assign atTerm    = (cnt == W'(curRatio - W'(1)));
  assign nextCnt   = atTerm ? '0 : W'(cnt + W'(1));
  assign nextRatio = atTerm ? ratioIn : curRatio;
  assign halfHigh  = ({1'b0, nextRatio} + (W+1)'(1)) >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      curRatio <= W'(1);
      divQ     <= 1'b0;
    end else if (hold) begin
      cnt      <= '0;
      curRatio <= W'(1);
      divQ     <= 1'b0;
    end else begin
      cnt      <= nextCnt;
      curRatio <= nextRatio;
      divQ     <= ({1'b0, nextCnt} < halfHigh);
    end
  end

  generate
    if (UNITY_PASS) begin : gUnity
      logic runQ, bypassQ;
      // switch the bypass on the falling edge so the mux never changes while clk is high
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) begin
          runQ    <= 1'b0;
          bypassQ <= 1'b0;
        end else begin
          runQ    <= !hold;
          bypassQ <= (curRatio == W'(1));
        end
      end
      assign divOut = bypassQ ? (clk & runQ) : divQ;
    end else begin : gPlain
      assign divOut = divQ;
    end
  endgenerate
endmodule

// File: rtl/pllDivCtrl.sv
module pllDivCtrl import pllDivPkg::*; #(
  parameter int P_OFFSET = 2,
  parameter int M_OFFSET = 8,
  parameter int P_MAX    = 62,
  parameter int M_MAX    = 248,
  parameter logic [CFG_W-1:0] CFG_RESET = 16'h1805
) (
  input  logic               refClk,
  input  logic               rstN,
  input  logic               powerDown,
  input  logic               useReg,
  input  logic               wrEn,
  input  logic [CFG_W-1:0]   wrData,
  input  logic [MCODE_W-1:0] pinM,
  input  logic [PCODE_W-1:0] pinP,
  input  logic [SCODE_W-1:0] pinS,
  output dpCtrl_t            dpCtrl,
  output logic               codeErr
);
  logic [CFG_W-1:0]   cfgReg;
  logic [MCODE_W-1:0] selM, clampM;
  logic [PCODE_W-1:0] selP, clampP;
  logic [SCODE_W-1:0] selS;
  logic mLow, mHigh, pLow, pHigh, errQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)     cfgReg <= CFG_RESET;
    else if (wrEn) cfgReg <= wrData;
  end

  assign selM = useReg ? cfgReg[CFG_W-1 -: MCODE_W]  : pinM;
  assign selP = useReg ? cfgReg[SCODE_W +: PCODE_W]  : pinP;
  assign selS = useReg ? cfgReg[SCODE_W-1:0]         : pinS;

  assign mLow  = (selM == '0);
  assign mHigh = (selM > MCODE_W'(M_MAX));
  assign pLow  = (selP == '0);
  assign pHigh = (selP > PCODE_W'(P_MAX));

  assign clampM = mLow ? MCODE_W'(1) : (mHigh ? MCODE_W'(M_MAX) : selM);
  assign clampP = pLow ? PCODE_W'(1) : (pHigh ? PCODE_W'(P_MAX) : selP);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= errQ | mLow | mHigh | pLow | pHigh;
  end
  assign codeErr = errQ;

  always_comb begin
    dpCtrl.hold      = powerDown;
    dpCtrl.preRatio  = PRE_RW'(clampP) + PRE_RW'(P_OFFSET);
    dpCtrl.fbRatio   = FB_RW'(clampM) + FB_RW'(M_OFFSET);
    dpCtrl.postRatio = POST_RW'(1) << selS;
  end
endmodule

// File: rtl/pllDivDatapath.sv
module pllDivDatapath import pllDivPkg::*; (
  input  logic    refClk,
  input  logic    vcoClk,
  input  logic    rstN,
  input  dpCtrl_t dpCtrl,
  output logic    refDivOut,
  output logic    fbDivOut,
  output logic    clkOut
);
  divCounter #(.W(PRE_RW), .UNITY_PASS(1'b0)) uPre (
    .clk(refClk), .rstN(rstN), .hold(dpCtrl.hold),
    .ratioIn(dpCtrl.preRatio), .divOut(refDivOut));

  divCounter #(.W(FB_RW), .UNITY_PASS(1'b0)) uFb (
    .clk(vcoClk), .rstN(rstN), .hold(dpCtrl.hold),
    .ratioIn(dpCtrl.fbRatio), .divOut(fbDivOut));

  divCounter #(.W(POST_RW), .UNITY_PASS(1'b1)) uPost (
    .clk(vcoClk), .rstN(rstN), .hold(dpCtrl.hold),
    .ratioIn(dpCtrl.postRatio), .divOut(clkOut));
endmodule

// File: rtl/pllDivChain.sv
module pllDivChain import pllDivPkg::*; #(
  parameter int P_OFFSET = 2,
  parameter int M_OFFSET = 8,
  parameter int P_MAX    = 62,
  parameter int M_MAX    = 248,
  parameter logic [CFG_W-1:0] CFG_RESET = 16'h1805
) (
  input  logic               refClk,
  input  logic               vcoClk,
  input  logic               rstN,
  input  logic               powerDown,
  input  logic               useReg,
  input  logic               wrEn,
  input  logic [CFG_W-1:0]   wrData,
  input  logic [MCODE_W-1:0] pinM,
  input  logic [PCODE_W-1:0] pinP,
  input  logic [SCODE_W-1:0] pinS,
  output logic               refDivOut,
  output logic               fbDivOut,
  output logic               clkOut,
  output logic               codeErr
);
  dpCtrl_t dpCtrl;

  pllDivCtrl #(
    .P_OFFSET(P_OFFSET), .M_OFFSET(M_OFFSET),
    .P_MAX(P_MAX), .M_MAX(M_MAX), .CFG_RESET(CFG_RESET)
  ) uCtrl (
    .refClk(refClk), .rstN(rstN), .powerDown(powerDown), .useReg(useReg),
    .wrEn(wrEn), .wrData(wrData), .pinM(pinM), .pinP(pinP), .pinS(pinS),
    .dpCtrl(dpCtrl), .codeErr(codeErr));

  pllDivDatapath uDp (
    .refClk(refClk), .vcoClk(vcoClk), .rstN(rstN), .dpCtrl(dpCtrl),
    .refDivOut(refDivOut), .fbDivOut(fbDivOut), .clkOut(clkOut));
endmodule

// File: rtl/pllDivChecker.sv
module pllDivChecker import pllDivPkg::*; #(
  parameter int REF_HI_MAX = 32,
  parameter int FB_HI_MAX  = 128
) (
  input logic               refClk,
  input logic               vcoClk,
  input logic               rstN,
  input logic               powerDown,
  input logic               useReg,
  input logic [PCODE_W-1:0] pinP,
  input logic [MCODE_W-1:0] pinM,
  input logic               refDivOut,
  input logic               fbDivOut,
  input logic               codeErr
);
  logic [15:0] refHi, fbHi;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)          refHi <= '0;
    else if (refDivOut) refHi <= refHi + 16'd1;
    else                refHi <= '0;
  end

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN)         fbHi <= '0;
    else if (fbDivOut) fbHi <= fbHi + 16'd1;
    else               fbHi <= '0;
  end

  assert_ref_run_R4: assert property (@(posedge refClk) disable iff (!rstN)
    refHi <= 16'(REF_HI_MAX));

  assert_fb_run_R4: assert property (@(posedge vcoClk) disable iff (!rstN)
    fbHi <= 16'(FB_HI_MAX));

  assert_ref_pd_low_R8: assert property (@(posedge refClk) disable iff (!rstN)
    powerDown |=> !refDivOut);

  assert_fb_pd_low_R8: assert property (@(posedge vcoClk) disable iff (!rstN)
    powerDown |=> !fbDivOut);

  assert_err_sticky_R7: assert property (@(posedge refClk) disable iff (!rstN)
    codeErr |=> codeErr);

  assert_err_on_zero_R6: assert property (@(posedge refClk) disable iff (!rstN)
    (!useReg && (pinP == '0 || pinM == '0)) |=> codeErr);
endmodule

bind pllDivChain pllDivChecker uChk (
  .refClk(refClk), .vcoClk(vcoClk), .rstN(rstN), .powerDown(powerDown),
  .useReg(useReg), .pinP(pinP), .pinM(pinM), .refDivOut(refDivOut),
  .fbDivOut(fbDivOut), .codeErr(codeErr));

// File: tb/sim_pllDivChain.sv
module sim_pllDivChain;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerDown = 1'b0, useReg = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0] pinM = 8'd1;
  logic [5:0] pinP = 6'd1;
  logic [1:0] pinS = 2'd1;
  logic refDivOut, fbDivOut, clkOut, codeErr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pllDivChain u0 (
    .refClk(clk), .vcoClk(clk), .rstN(rstN), .powerDown(powerDown),
    .useReg(useReg), .wrEn(wrEn), .wrData(wrData), .pinM(pinM),
    .pinP(pinP), .pinS(pinS), .refDivOut(refDivOut), .fbDivOut(fbDivOut),
    .clkOut(clkOut), .codeErr(codeErr));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stepS(); @(posedge clk); #1; endtask
  task automatic stepN(); @(negedge clk); #1; endtask

  function automatic logic sig(int sel);
    case (sel)
      0: return refDivOut;
      1: return fbDivOut;
      default: return clkOut;
    endcase
  endfunction

  task automatic waitRise(int sel);
    logic prev;
    prev = sig(sel);
    for (int i = 0; i < 2000; i++) begin
      stepS();
      if (!prev && sig(sel)) return;
      prev = sig(sel);
    end
  endtask

  task automatic runLen(int sel, logic val, output int n);
    n = 1;
    for (int i = 0; i < 2000; i++) begin
      stepS();
      if (sig(sel) != val) return;
      n++;
    end
  endtask

  task automatic measure(int sel, int ratio, string req);
    int hi, lo;
    waitRise(sel);
    runLen(sel, 1'b1, hi);
    runLen(sel, 1'b0, lo);
    check({req, " period"}, hi + lo, ratio);
    check("R4 high run", hi, (ratio + 1) / 2);
  endtask

  task automatic writeCfg(logic [7:0] m, logic [5:0] p, logic [1:0] s);
    wrData = {m, p, s};
    wrEn = 1'b1;
    stepS();
    wrEn = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo, ones;
    int mList[13] = '{1, 2, 3, 7, 8, 50, 100, 127, 128, 200, 246, 247, 248};
    // reset state
    stepS(); stepS();
    check("R8 reset ref low", refDivOut, 0);
    check("R8 reset fb low", fbDivOut, 0);
    check("R7 reset err", codeErr, 0);
    rstN = 1'b1;

    // R5: register source, pins set to different legal values
    pinP = 6'd10; pinM = 8'd10; pinS = 2'd3;
    writeCfg(8'd20, 6'd5, 2'd2);
    useReg = 1'b1;
    measure(0, 7, "R5 reg P");
    measure(1, 28, "R5 reg M");
    measure(2, 4, "R5 reg S");
    useReg = 1'b0;
    measure(0, 12, "R5 pin P");
    check("R7 no err on legal", codeErr, 0);

    // R1: every legal reference code
    for (int p = 1; p <= 62; p++) begin
      pinP = 6'(p);
      measure(0, p + 2, "R1");
    end
    // R2: feedback codes across the range
    for (int k = 0; k < 13; k++) begin
      pinM = 8'(mList[k]);
      measure(1, mList[k] + 8, "R2");
    end
    // R3: scaler codes
    for (int s = 3; s >= 1; s--) begin
      pinS = 2'(s);
      measure(2, 1 << s, "R3");
    end
    pinS = 2'd0;
    for (int i = 0; i < 20; i++) stepS();
    for (int i = 0; i < 4; i++) begin
      stepS(); check("R3 bypass high", clkOut, 1);
      stepN(); check("R3 bypass low", clkOut, 0);
    end
    check("R7 still no err", codeErr, 0);

    // R6 clamps and R7 flag
    pinP = 6'd0; stepS();
    check("R7 err set", codeErr, 1);
    measure(0, 3, "R6 P=0");
    pinP = 6'd63; measure(0, 64, "R6 P=63");
    pinP = 6'd4;
    pinM = 8'd0; measure(1, 9, "R6 M=0");
    pinM = 8'd249; measure(1, 256, "R6 M=249");
    pinM = 8'd255; measure(1, 256, "R6 M=255");
    writeCfg(8'd255, 6'd0, 2'd1);
    useReg = 1'b1;
    measure(0, 3, "R6 reg P=0");
    measure(1, 256, "R6 reg M=255");
    useReg = 1'b0;
    pinM = 8'd16;
    for (int i = 0; i < 300; i++) stepS();
    check("R7 err sticky", codeErr, 1);

    // R9: change mid-period
    pinP = 6'd62;
    waitRise(0);
    runLen(0, 1'b1, hi); runLen(0, 1'b0, lo);
    waitRise(0);
    pinP = 6'd1;
    runLen(0, 1'b1, hi);
    check("R9 old high", hi, 32);
    runLen(0, 1'b0, lo);
    check("R9 old low", lo, 32);
    runLen(0, 1'b1, hi);
    check("R9 new high", hi, 2);
    runLen(0, 1'b0, lo);
    check("R9 new low", lo, 1);

    // R8 power-down
    pinS = 2'd1;
    powerDown = 1'b1;
    stepS(); stepS();
    ones = 0;
    for (int i = 0; i < 50; i++) begin
      stepS(); ones += refDivOut + fbDivOut + clkOut;
      stepN(); ones += refDivOut + fbDivOut + clkOut;
    end
    check("R8 outputs held low", ones, 0);
    stepS();
    powerDown = 1'b0;
    stepS();
    check("R8 ref first edge", refDivOut, 1);
    check("R8 fb first edge", fbDivOut, 1);
    measure(0, 3, "R8 ref after wake");

    // R7 cleared only by reset
    rstN = 1'b0;
    stepS();
    check("R7 err cleared by reset", codeErr, 0);
    rstN = 1'b1;
    stepS();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule